// File: doc/BRIEF.md
# Dual-Rail Word Link with Completion Detection

This block carries a parallel word across a dual-rail link and finds out, without any separate strobe, when the whole word has arrived. On the transmit side a small state machine takes a word on a one-cycle send strobe. It spreads the word over two wires per bit, a true wire and a false wire. It holds that code until the receiver reports completion. It then drives every pair back to the empty code and waits for the receiver to see the empty state before it accepts another word. Two successive words are therefore always separated by an all-empty phase.

On the receive side each bit pair is decoded on its own. A per-bit hold cell records whether that pair has most recently shown a data code or the empty code. These cells feed a tree of two-input hold-state cells that behave as Muller C-elements: an output goes high only when both inputs are high, goes low only when both are low, and otherwise keeps its value. The root of the tree is the completion flag. The decoded word is captured on the edge where that flag rises. A pair showing both wires high is illegal and is reported on an error output.

The receive input is a separate port, so the link is closed outside the block. In normal use the transmit rails are wired to the receive rails. The completion flag also serves internally as the transmitter's acknowledge.

Sender states: `TX_IDLE` (empty code, accepts a send strobe), `TX_DATA` (word code held on the rails) and `TX_RTZ` (empty code, waiting for completion to drop). Transitions: `TX_IDLE`→`TX_DATA` on a send strobe; `TX_DATA`→`TX_RTZ` when completion is high; `TX_RTZ`→`TX_IDLE` when completion is low.

Top module: `dr_link`

## Requirements
- R1: Bit i of the word uses the rail pair at bus positions 2i+1 (true wire) and 2i (false wire). A logic 1 is sent as pair value 2'b10, a logic 0 as 2'b01, and the empty (spacer) code is 2'b00. 2'b11 is illegal. A word of WIDTH bits uses 2*WIDTH wires.
- R2: While reset is low, and on its release, the transmit rails are all spacer and the completion flag, received word and error output are all zero.
- R3: A send strobe sampled in `TX_IDLE` puts the word's code on the transmit rails after that same clock edge. The code stays there until completion is seen high. The rails then return to all-spacer until completion is seen low, and only after that does the sender go back to `TX_IDLE`.
- R4: A send strobe sampled while the sender is in `TX_DATA` or `TX_RTZ` is ignored. It changes neither the rails nor the word later delivered.
- R5: The completion flag rises on the clock edge after every pair of the receive rails first holds a data code (01 or 10).
- R6: While some pairs hold data and others spacer, the completion flag keeps its previous value, whether it was low or high.
- R7: The completion flag falls on the clock edge after every pair of the receive rails holds spacer.
- R8: The received word loads the true-wire values of the receive rails on the edge where the completion flag rises, and holds its value at every other edge.
- R9: The error output is high for the cycle after any receive pair shows 2'b11 and low otherwise. A pair at 2'b11 counts neither as data nor as spacer, so it cannot make completion rise or fall.
- R10: The transmit rails never change directly from one data word to a different one. Any change between words passes through all-spacer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_word | input | WIDTH | Word to send |
| tx_send | input | 1 | One-cycle send strobe, used only in `TX_IDLE` |
| tx_rails | output | 2*WIDTH | Transmit dual-rail bus |
| rx_rails | input | 2*WIDTH | Receive dual-rail bus |
| rx_word | output | WIDTH | Word captured when completion rises |
| rx_done | output | 1 | Completion flag (root of the C-element tree) |
| rx_err | output | 1 | A receive pair showed 2'b11 in the previous cycle |

## Verification
The embedded properties watch every cycle for these rules: completion only rises after an all-data cycle and only falls after an all-spacer cycle; it holds through mixed states; the received word moves only on a completion rise; the transmit rails never jump between two words; and the sender stays in its data state until acknowledged. The exact wire mapping of each value, the cycle in which completion appears after a send or a rail change, the effect of ignored send strobes, and the way an illegal pair blocks completion until it is repaired can only be shown by the bench. It does this with scenarios driven through the looped-back link and with rail patterns injected directly at the receive port.

// File: rtl/dr_link_pkg.sv
package dr_link_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_DATA = 2'd1,
        TX_RTZ  = 2'd2
    } tx_state_e;

    // Pair value is {true wire, false wire}
    localparam logic [1:0] PAIR_EMPTY = 2'b00;
    localparam logic [1:0] PAIR_ZERO  = 2'b01;
    localparam logic [1:0] PAIR_ONE   = 2'b10;
    localparam logic [1:0] PAIR_BAD   = 2'b11;

    function automatic logic [1:0] pair_of(input logic b);
        return b ? PAIR_ONE : PAIR_ZERO;
    endfunction

endpackage

// File: rtl/dr_sender.sv
module dr_sender
    import dr_link_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH-1:0]   word_i,
    input  logic               send_i,
    input  logic               ack_i,
    output logic [2*WIDTH-1:0] rails_o
);

    localparam int unsigned RAILS = 2 * WIDTH;

    tx_state_e          state_q, state_d;
    logic [WIDTH-1:0]   word_q;
    logic [RAILS-1:0]   code;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (send_i)  state_d = TX_DATA;
            TX_DATA: if (ack_i)   state_d = TX_RTZ;
            TX_RTZ:  if (!ack_i)  state_d = TX_IDLE;
            default:              state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             word_q <= '0;
        else if (state_q == TX_IDLE && send_i)  word_q <= word_i;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_enc
        assign code[2*i+1 -: 2] = pair_of(word_q[i]);
    end

    // outputs
    always_comb begin
        rails_o = '0;
        unique case (state_q)
            TX_DATA: rails_o = code;
            default: rails_o = '0;
        endcase
    end

    AST_RAILS_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        ((rails_o != '0) && ($past(rails_o) != '0)) |-> (rails_o == $past(rails_o))); // R10

    AST_DATA_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_DATA && !ack_i) |=> (state_q == TX_DATA)); // R3

endmodule

// File: rtl/dr_rail_cell.sv
module dr_rail_cell
    import dr_link_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pair_i,
    output logic       data_o,
    output logic       empty_o,
    output logic       bad_o,
    output logic       bit_o,
    output logic       leaf_o
);

    logic hold_q;

    assign data_o  = (pair_i == PAIR_ZERO) || (pair_i == PAIR_ONE);
    assign empty_o = (pair_i == PAIR_EMPTY);
    assign bad_o   = (pair_i == PAIR_BAD);
    assign bit_o   = pair_i[1];

    // leaf C-element: set on data, clear on empty, hold otherwise
    assign leaf_o = data_o | (hold_q & ~empty_o);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= leaf_o;
    end

endmodule

// File: rtl/dr_c_tree.sv
module dr_c_tree #(
    parameter int unsigned LEAVES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEAVES-1:0] leaf_i,
    output logic              root_o,
    output logic              done_o
);

    localparam int unsigned LEVELS = (LEAVES < 2) ? 1 : $clog2(LEAVES);
    localparam int unsigned SPAN   = 1 << LEVELS;

    logic [2*SPAN-1:1] node;
    logic [SPAN-1:1]   hold_q;

    for (genvar j = 0; j < SPAN; j++) begin : g_leaf
        if (j < LEAVES) begin : g_real
            assign node[SPAN+j] = leaf_i[j];
        end else begin : g_pad
            assign node[SPAN+j] = leaf_i[0];
        end
    end

    for (genvar n = 1; n < SPAN; n++) begin : g_cel
        assign node[n] = (node[2*n] & node[2*n+1]) |
                         (hold_q[n] & (node[2*n] | node[2*n+1]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else begin
            for (int n = 1; n < SPAN; n++) hold_q[n] <= node[n];
        end
    end

    assign root_o = node[1];
    assign done_o = hold_q[1];

endmodule

// File: rtl/dr_link.sv
module dr_link #(
    parameter int unsigned WIDTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WIDTH-1:0]     tx_word,
    input  logic                 tx_send,
    output logic [2*WIDTH-1:0]   tx_rails,
    input  logic [2*WIDTH-1:0]   rx_rails,
    output logic [WIDTH-1:0]     rx_word,
    output logic                 rx_done,
    output logic                 rx_err
);

    logic [WIDTH-1:0] bit_data, bit_empty, bit_bad, bit_val, bit_leaf;
    logic             root_z;
    logic             all_data, all_empty, any_bad;
    logic [WIDTH-1:0] word_q;
    logic             err_q;

    dr_sender #(.WIDTH(WIDTH)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_i  (tx_word),
        .send_i  (tx_send),
        .ack_i   (rx_done),
        .rails_o (tx_rails)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        dr_rail_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .pair_i  (rx_rails[2*i+1 -: 2]),
            .data_o  (bit_data[i]),
            .empty_o (bit_empty[i]),
            .bad_o   (bit_bad[i]),
            .bit_o   (bit_val[i]),
            .leaf_o  (bit_leaf[i])
        );
    end

    dr_c_tree #(.LEAVES(WIDTH)) u_tree (
        .clk    (clk),
        .rst_n  (rst_n),
        .leaf_i (bit_leaf),
        .root_o (root_z),
        .done_o (rx_done)
    );

    assign all_data  = &bit_data;
    assign all_empty = &bit_empty;
    assign any_bad   = |bit_bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (root_z && !rx_done) word_q <= bit_val;
            err_q <= any_bad;
        end
    end

    assign rx_word = word_q;
    assign rx_err  = err_q;

    AST_DONE_RISE_ALL_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(all_data)); // R5

    AST_DONE_FALL_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_done) |-> $past(all_empty)); // R7

    AST_DONE_HOLD_MIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_data && !all_empty) |=> $stable(rx_done)); // R6

    AST_WORD_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(rx_done) |-> $stable(rx_word)); // R8

endmodule

// File: tb/sim_dr_link.sv
`timescale 1ns/1ps
module sim_dr_link;

    localparam int unsigned W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [W-1:0]   tx_word = '0;
    logic           tx_send = 1'b0;
    logic [2*W-1:0] tx_rails;
    logic [2*W-1:0] rx_rails;
    logic [W-1:0]   rx_word;
    logic           rx_done;
    logic           rx_err;
    logic           inj_en = 1'b0;
    logic [2*W-1:0] inj_rails = '0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit ended  = 1'b0;

    logic [W-1:0]   exp_q[$];
    logic           prev_done = 1'b0;
    logic [2*W-1:0] prev_rails = '0;

    always #2 clk = ~clk;  // 250 MHz

    assign rx_rails = inj_en ? inj_rails : tx_rails;

    dr_link #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_word(tx_word), .tx_send(tx_send),
        .tx_rails(tx_rails), .rx_rails(rx_rails), .rx_word(rx_word),
        .rx_done(rx_done), .rx_err(rx_err)
    );

    function automatic logic [2*W-1:0] enc(input logic [W-1:0] w);
        logic [2*W-1:0] r;
        for (int i = 0; i < W; i++) begin
            r[2*i+1] = w[i];
            r[2*i]   = ~w[i];
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: scoreboard pop on completion rise, monotonic rail watch
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_done && !prev_done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected word", {24'd0, rx_word}, 32'd0);
                end else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    chk(rx_word == e, "R8 word", {24'd0, rx_word}, {24'd0, e});
                end
            end
            if (tx_rails != '0 && prev_rails != '0)
                chk(tx_rails == prev_rails, "R10 rails", {16'd0, tx_rails}, {16'd0, prev_rails});
        end
        prev_done  = rx_done;
        prev_rails = tx_rails;
    end

    // driver: send a word through the looped link, optional intruding strobes
    task automatic send_word(input logic [W-1:0] w, input bit intrude);
        @(negedge clk);
        tx_word = w; tx_send = 1'b1;
        exp_q.push_back(w);
        @(negedge clk);                       // after edge k: TX_DATA
        chk(tx_rails == enc(w), "R1 encode", {16'd0, tx_rails}, {16'd0, enc(w)});
        if (intrude) begin tx_word = ~w; tx_send = 1'b1; end
        else tx_send = 1'b0;
        @(negedge clk);                       // after k+1: done high
        chk(rx_done == 1'b1, "R5 done rise", {31'd0, rx_done}, 32'd1);
        chk(tx_rails == enc(w), "R4 rails kept", {16'd0, tx_rails}, {16'd0, enc(w)});
        @(negedge clk);                       // after k+2: TX_RTZ
        chk(tx_rails == '0, "R3 spacer phase", {16'd0, tx_rails}, 32'd0);
        chk(rx_done == 1'b1, "R3 done held", {31'd0, rx_done}, 32'd1);
        @(negedge clk);                       // after k+3: done low
        chk(rx_done == 1'b0, "R7 done fall", {31'd0, rx_done}, 32'd0);
        tx_send = 1'b0;
        @(negedge clk);                       // after k+4: TX_IDLE
        chk(tx_rails == '0, "R3 idle", {16'd0, tx_rails}, 32'd0);
        if (intrude) begin
            @(negedge clk);
            chk(tx_rails == '0 && exp_q.size() == 0, "R4 strobe ignored",
                {16'd0, tx_rails}, 32'd0);
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !ended) begin
            ended = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(tx_rails == '0 && rx_done == 1'b0 && rx_word == '0 && rx_err == 1'b0,
            "R2 in reset", {16'd0, tx_rails}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_rails == '0 && rx_done == 1'b0 && rx_word == '0 && rx_err == 1'b0,
            "R2 after reset", {31'd0, rx_done}, 32'd0);

        // looped link
        send_word(8'hA5, 1'b0);
        send_word(8'h00, 1'b0);
        send_word(8'hFF, 1'b1);
        send_word(8'h5A, 1'b0);
        send_word(8'h81, 1'b1);

        // injected rail patterns
        inj_en = 1'b1; inj_rails = '0;
        @(negedge clk);
        inj_rails = {8'h00, enc(8'hC3)[7:0]};   // low half data, high half spacer
        @(negedge clk);
        chk(rx_done == 1'b0, "R6 mixed stays low", {31'd0, rx_done}, 32'd0);
        exp_q.push_back(8'hC3);
        inj_rails = enc(8'hC3);
        @(negedge clk);
        chk(rx_done == 1'b1, "R5 all data", {31'd0, rx_done}, 32'd1);
        inj_rails = {8'h00, enc(8'hC3)[7:0]};
        @(negedge clk);
        chk(rx_done == 1'b1, "R6 mixed stays high", {31'd0, rx_done}, 32'd1);
        chk(rx_word == 8'hC3, "R8 word held", {24'd0, rx_word}, 32'hC3);
        inj_rails = '0;
        @(negedge clk);
        chk(rx_done == 1'b0, "R7 all spacer", {31'd0, rx_done}, 32'd0);

        // illegal pair on bit 3
        inj_rails = 16'h00C0;
        @(negedge clk);
        chk(rx_err == 1'b1, "R9 error flag", {31'd0, rx_err}, 32'd1);
        chk(rx_done == 1'b0, "R9 no done", {31'd0, rx_done}, 32'd0);
        inj_rails = enc(8'h3C);
        inj_rails[7:6] = 2'b11;
        @(negedge clk);
        chk(rx_done == 1'b0, "R9 bad not data", {31'd0, rx_done}, 32'd0);
        chk(rx_err == 1'b1, "R9 error persists", {31'd0, rx_err}, 32'd1);
        exp_q.push_back(8'h3C);
        inj_rails = enc(8'h3C);
        @(negedge clk);
        chk(rx_done == 1'b1, "R5 after repair", {31'd0, rx_done}, 32'd1);
        chk(rx_err == 1'b0, "R9 error clears", {31'd0, rx_err}, 32'd0);
        inj_rails[7:6] = 2'b11;                  // bad while complete
        @(negedge clk);
        chk(rx_done == 1'b1, "R9 bad not spacer", {31'd0, rx_done}, 32'd1);
        inj_rails = '0;
        @(negedge clk);
        chk(rx_done == 1'b0, "R7 final spacer", {31'd0, rx_done}, 32'd0);
        chk(rx_word == 8'h3C, "R8 word kept", {24'd0, rx_word}, 32'h3C);
        inj_en = 1'b0;

        send_word(8'h96, 1'b0);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R8 all words delivered", exp_q.size(), 32'd0);

        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule